// File: doc/BRIEF.md
# Mode-Configurable Accelerator Slot Distributor

This block sits between a burst-capable data bus and a row of accelerator slots. It has two jobs: feeding input data to the slots and collecting their results. It supports two ways of working, and the choice can change between invocations.

In split mode, one incoming burst is cut into equal consecutive chunks, one chunk for each enabled slot, taken in ascending slot order. A slot gets its start strobe as soon as its own chunk is complete, so it computes while later slots are still loading. In the two redundant modes, the same words go to a fixed group of slots in the same cycles. The group is slots 0 and 1 for double redundancy, or slots 0, 1 and 2 for triple redundancy. Results come back through a voter.

Results are read back only after every slot of the round has reported done. In split mode they are concatenated in ascending slot order. In redundant mode each result word is read from the whole group at once and voted. A kernel with more work-groups than slots runs as several successive rounds, each started with its own pulse.

Top module: `slot_distributor`

## Requirements
- R1: After reset, `busy`, `out_valid`, `vote_err`, `slot_we`, `slot_re` and `slot_start` are all low.
- R2: A `cfg_we` pulse while idle loads mask, mode and chunk length. The mode codes are 0 split, 1 double redundancy, 2 triple redundancy and 3 split. A `cfg_we` pulse while busy is ignored, so the next round still uses the old configuration.
- R3: In split mode a burst has `cfg_len` × popcount(`cfg_mask`) words. Word n goes to the (n / len)-th enabled slot in ascending order, at `slot_waddr` = n mod len. `slot_we` is raised in the same cycle that `in_valid` is high. Cycles where `in_valid` is low write nothing.
- R4: `slot_start[i]` is a single-cycle pulse, raised one cycle after the cycle that carried slot i's last word.
- R5: In redundant mode every word is written to all group slots in the same cycle, and the whole group gets its start pulse together.
- R6: Read-back begins only after every slot of the round has raised `slot_done` after its own start pulse. A done left over from before or during the start pulse does not count. No write and no read happen in the same cycle.
- R7: Each result appears on `out_data` with `out_valid` one cycle after its `slot_re`. Split-mode results come slot by slot in ascending order, with addresses 0 to len-1 within each slot.
- R8: In triple mode `out_data` is the bitwise majority of slots 0, 1 and 2. `vote_err` is high with that word if any of the three words differ.
- R9: In double mode `out_data` is slot 0's word. `vote_err` is high with that word if slot 0 and slot 1 differ.
- R10: `busy` rises the cycle after an accepted start and stays high through the cycle of the last result word. A start pulse is ignored while busy, when the length is 0, or in split mode with an empty mask.
- R11: Rounds may follow one another, and the configuration may change between rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_mask | input | NSLOT | Enabled slots for split mode |
| cfg_mode | input | 2 | Mode code |
| cfg_len | input | LENW | Words per slot chunk |
| start | input | 1 | Begin one round |
| in_valid | input | 1 | Burst word present |
| in_data | input | DW | Burst word |
| slot_we | output | NSLOT | Per-slot write enable |
| slot_waddr | output | LENW | Word index inside the chunk |
| slot_wdata | output | DW | Write data shared by all slots |
| slot_start | output | NSLOT | Per-slot start pulse |
| slot_done | input | NSLOT | Per-slot done level |
| slot_re | output | NSLOT | Per-slot result read enable |
| slot_raddr | output | LENW | Result word index |
| slot_rdata | input | NSLOT*DW | Result words, one cycle after read |
| out_valid | output | 1 | Result word present |
| out_data | output | DW | Result word, selected or voted |
| vote_err | output | 1 | Redundant disagreement on this word |
| busy | output | 1 | Round in progress |

## Verification
The bound checker watches the following on every cycle:
- split-mode writes and reads hit at most one slot;
- start pulses never last two cycles;
- writes and reads never overlap;
- results and vote errors only appear while busy;
- busy only falls right after a result word;
- the mode register never moves during a round.

Some behaviours depend on stimulus and only the bench scenarios can show them:
- which slot each word reaches, and when that slot is released;
- the order and values of the results;
- the majority and mismatch outcomes under injected slot faults;
- that a stale done level does not trigger an early read-back;
- that configuration writes and start pulses issued mid-round are ignored.

// File: rtl/dist_pkg.sv
// Shared types for the slot distributor.
// Assumes nothing beyond the 2-bit mode code and the five controller phases.
package dist_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'd0,
        MODE_DUAL   = 2'd1,
        MODE_TRIPLE = 2'd2,
        MODE_SPLIT2 = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_READ,
        ST_LAST
    } state_e;
endpackage

// File: rtl/dist_pick.sv
// Finds the lowest set bit of a slot mask at or above a given index.
// Purely combinational. The index may be NSLOT, meaning "none left".
module dist_pick #(
    parameter int NSLOT = 4,
    parameter int SW    = 2
) (
    input  logic [NSLOT-1:0] mask,
    input  logic [SW:0]      lo,
    output logic             found,
    output logic [SW-1:0]    idx
);
    // scan downward so the lowest qualifying slot wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(lo))) begin
                found = 1'b1;
                idx   = SW'(i);
            end
        end
    end
endmodule

// File: rtl/dist_voter.sv
// Return-path selector and voter.
// In split mode it passes the selected slot's word through.
// In double mode it passes slot 0 and flags any difference from slot 1.
// In triple mode it forms the bitwise majority of slots 0..2 and flags any disagreement.
// Assumes NSLOT >= 3.
module dist_voter #(
    parameter int NSLOT = 4,
    parameter int DW    = 8,
    parameter int SW    = 2
) (
    input  logic [NSLOT*DW-1:0] rdata,
    input  logic [SW-1:0]       sel,
    input  dist_pkg::mode_e     mode,
    output logic [DW-1:0]       word,
    output logic                mismatch
);
    import dist_pkg::*;

    logic [DW-1:0] w [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
        assign w[g] = rdata[g*DW +: DW];
    end

    // choose or vote the outgoing result word
    always_comb begin
        case (mode)
            MODE_TRIPLE: begin
                word     = (w[0] & w[1]) | (w[0] & w[2]) | (w[1] & w[2]);
                mismatch = (w[0] != w[1]) || (w[0] != w[2]);
            end
            MODE_DUAL: begin
                word     = w[0];
                mismatch = (w[0] != w[1]);
            end
            default: begin
                word     = w[sel];
                mismatch = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/slot_distributor.sv
// Distributes a burst to accelerator slots and collects their results.
// Split mode deals consecutive chunks to the enabled slots in ascending order.
// Redundant modes broadcast to slots 0..1 or 0..2 and vote on the way back.
// Assumes each slot reports results one cycle after slot_re, and drops
// slot_done on the cycle after it sees its start pulse.
module slot_distributor #(
    parameter int NSLOT = 4,
    parameter int DW    = 8,
    parameter int LENW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [NSLOT-1:0]    cfg_mask,
    input  logic [1:0]          cfg_mode,
    input  logic [LENW-1:0]     cfg_len,
    input  logic                start,
    input  logic                in_valid,
    input  logic [DW-1:0]       in_data,
    output logic [NSLOT-1:0]    slot_we,
    output logic [LENW-1:0]     slot_waddr,
    output logic [DW-1:0]       slot_wdata,
    output logic [NSLOT-1:0]    slot_start,
    input  logic [NSLOT-1:0]    slot_done,
    output logic [NSLOT-1:0]    slot_re,
    output logic [LENW-1:0]     slot_raddr,
    input  logic [NSLOT*DW-1:0] slot_rdata,
    output logic                out_valid,
    output logic [DW-1:0]       out_data,
    output logic                vote_err,
    output logic                busy
);
    import dist_pkg::*;

    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    state_e           state;
    mode_e            mode_q;
    logic [NSLOT-1:0] mask_q;
    logic [LENW-1:0]  len_q;
    logic [SW-1:0]    cur_q;
    logic [SW-1:0]    sel_q;
    logic [LENW-1:0]  idx_q;
    logic [NSLOT-1:0] strobed_q;
    logic [NSLOT-1:0] seen_q;
    logic [NSLOT-1:0] start_q;
    logic             rd_q;

    logic             is_split;
    logic [NSLOT-1:0] grp;
    logic [NSLOT-1:0] tgt;
    logic             last_idx;
    logic             first_found;
    logic             next_found;
    logic [SW-1:0]    first_idx;
    logic [SW-1:0]    next_idx;
    logic             start_ok;
    logic [DW-1:0]    vote_word;
    logic             vote_bad;

    // decode the mode into the round's slot group and this cycle's target slots
    always_comb begin
        is_split = !((mode_q == MODE_DUAL) || (mode_q == MODE_TRIPLE));
        case (mode_q)
            MODE_DUAL:   grp = NSLOT'(2'b11);
            MODE_TRIPLE: grp = NSLOT'(3'b111);
            default:     grp = mask_q;
        endcase
        tgt      = is_split ? (NSLOT'(1) << cur_q) : grp;
        last_idx = (idx_q == len_q - LENW'(1));
        start_ok = (state == ST_IDLE) && start && (len_q != '0) &&
                   (!is_split || first_found);
    end

    dist_pick #(.NSLOT(NSLOT), .SW(SW)) u_first (
        .mask  (mask_q),
        .lo    ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    dist_pick #(.NSLOT(NSLOT), .SW(SW)) u_next (
        .mask  (mask_q),
        .lo    ((SW+1)'(cur_q) + (SW+1)'(1)),
        .found (next_found),
        .idx   (next_idx)
    );

    // configuration registers, writable only between rounds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SPLIT;
            mask_q <= '0;
            len_q  <= '0;
        end else if (cfg_we && (state == ST_IDLE)) begin
            mode_q <= mode_e'(cfg_mode);
            mask_q <= cfg_mask;
            len_q  <= cfg_len;
        end
    end

    // round controller: load chunks, wait for done, read back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_q     <= '0;
            sel_q     <= '0;
            idx_q     <= '0;
            strobed_q <= '0;
            seen_q    <= '0;
            start_q   <= '0;
            rd_q      <= 1'b0;
        end else begin
            start_q <= '0;
            rd_q    <= 1'b0;
            if ((state == ST_LOAD) || (state == ST_WAIT))
                seen_q <= seen_q | (slot_done & strobed_q & ~start_q);
            case (state)
                ST_IDLE: if (start_ok) begin
                    state     <= ST_LOAD;
                    cur_q     <= is_split ? first_idx : '0;
                    idx_q     <= '0;
                    strobed_q <= '0;
                    seen_q    <= '0;
                end
                ST_LOAD: if (in_valid) begin
                    if (last_idx) begin
                        idx_q     <= '0;
                        start_q   <= tgt;
                        strobed_q <= strobed_q | tgt;
                        if (is_split && next_found) cur_q <= next_idx;
                        else                        state <= ST_WAIT;
                    end else begin
                        idx_q <= idx_q + LENW'(1);
                    end
                end
                ST_WAIT: if ((seen_q & grp) == grp) begin
                    state <= ST_READ;
                    cur_q <= is_split ? first_idx : '0;
                    idx_q <= '0;
                end
                ST_READ: begin
                    rd_q  <= 1'b1;
                    sel_q <= cur_q;
                    if (last_idx) begin
                        idx_q <= '0;
                        if (is_split && next_found) cur_q <= next_idx;
                        else                        state <= ST_LAST;
                    end else begin
                        idx_q <= idx_q + LENW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    dist_voter #(.NSLOT(NSLOT), .DW(DW), .SW(SW)) u_voter (
        .rdata    (slot_rdata),
        .sel      (sel_q),
        .mode     (mode_q),
        .word     (vote_word),
        .mismatch (vote_bad)
    );

    // drive the slot-side ports and the result port
    always_comb begin
        slot_we    = ((state == ST_LOAD) && in_valid) ? tgt : '0;
        slot_waddr = idx_q;
        slot_wdata = in_data;
        slot_start = start_q;
        slot_re    = (state == ST_READ) ? tgt : '0;
        slot_raddr = idx_q;
        out_valid  = rd_q;
        out_data   = vote_word;
        vote_err   = rd_q && vote_bad;
        busy       = (state != ST_IDLE);
    end
endmodule

// File: rtl/dist_checker.sv
// Cycle-level properties of the slot distributor. Attached by bind below.
// Assumes the mode register and the split decode are passed in from the design.
module dist_checker #(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSLOT-1:0] slot_we,
    input logic [NSLOT-1:0] slot_re,
    input logic [NSLOT-1:0] slot_start,
    input logic             out_valid,
    input logic             vote_err,
    input logic             busy,
    input logic             is_split,
    input logic [1:0]       mode_q
);
    assert_split_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_split |-> $onehot0(slot_we));

    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_start) |=> ((slot_start & $past(slot_start)) == '0));

    assert_no_rw_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|slot_we) && (|slot_re)));

    assert_split_re_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_split |-> $onehot0(slot_re));

    assert_err_with_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vote_err |-> out_valid);

    assert_out_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    assert_busy_ends_on_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid));

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));
endmodule

bind slot_distributor dist_checker #(.NSLOT(NSLOT)) u_dist_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_we    (slot_we),
    .slot_re    (slot_re),
    .slot_start (slot_start),
    .out_valid  (out_valid),
    .vote_err   (vote_err),
    .busy       (busy),
    .is_split   (is_split),
    .mode_q     (mode_q)
);

// File: tb/test_slot_distributor.sv
// Bench: behavioural slot models, a queue-based result model and per-cycle
// comparison of the write, start and result ports.
module test_slot_distributor;
    localparam int NS = 4;
    localparam int DW = 8;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [NS-1:0] cfg_mask = '0;
    logic [1:0]    cfg_mode = '0;
    logic [LW-1:0] cfg_len = '0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [NS-1:0] slot_we, slot_start, slot_re;
    logic [NS-1:0] slot_done;
    logic [LW-1:0] slot_waddr, slot_raddr;
    logic [DW-1:0] slot_wdata, out_data;
    logic [NS*DW-1:0] slot_rdata;
    logic          out_valid, vote_err, busy;

    always #10 clk = ~clk;

    slot_distributor #(.NSLOT(NS), .DW(DW), .LENW(LW)) i_slot_distributor (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
        .cfg_mode(cfg_mode), .cfg_len(cfg_len), .start(start),
        .in_valid(in_valid), .in_data(in_data), .slot_we(slot_we),
        .slot_waddr(slot_waddr), .slot_wdata(slot_wdata),
        .slot_start(slot_start), .slot_done(slot_done), .slot_re(slot_re),
        .slot_raddr(slot_raddr), .slot_rdata(slot_rdata),
        .out_valid(out_valid), .out_data(out_data), .vote_err(vote_err),
        .busy(busy)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fx(input logic [7:0] x);
        return 8'(x * 3 + 8'h11);
    endfunction

    // behavioural accelerator slots
    logic [7:0] mem [NS][16];
    logic [7:0] rq [NS];
    int         cnt [NS];
    int         dly [NS];
    logic [7:0] fault [NS];

    always @(posedge clk) begin
        for (int i = 0; i < NS; i++) begin
            if (!rst_n) begin
                slot_done[i] <= 1'b1;
                cnt[i]       <= 0;
                rq[i]        <= '0;
            end else begin
                if (slot_we[i]) mem[i][slot_waddr[3:0]] <= slot_wdata;
                if (slot_re[i]) rq[i] <= fx(mem[i][slot_raddr[3:0]]) ^ fault[i];
                if (slot_start[i]) begin
                    slot_done[i] <= 1'b0;
                    cnt[i]       <= dly[i];
                end else if (cnt[i] > 0) begin
                    cnt[i] <= cnt[i] - 1;
                    if (cnt[i] == 1) slot_done[i] <= 1'b1;
                end
            end
        end
    end
    assign slot_rdata = {rq[3], rq[2], rq[1], rq[0]};

    // bench view of configuration and expectations
    int            b_mode = 0;
    logic [NS-1:0] b_mask = '0;
    int            b_len  = 0;
    logic [NS-1:0] b_grp  = '0;
    logic [7:0]    exp_q [$];
    logic          err_q [$];
    logic [NS-1:0] exp_we = '0;
    logic [NS-1:0] exp_start = '0;
    int            exp_addr = 0;
    bit            chk_en = 1'b0;
    bit            prev_busy = 1'b0;
    bit            prev_ov = 1'b0;

    function automatic logic [NS-1:0] group_of(input int m, input logic [NS-1:0] mk);
        if (m == 1) return NS'(2'b11);
        if (m == 2) return NS'(3'b111);
        return mk;
    endfunction

    // per-cycle comparison, sampled away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_en) begin
                check(slot_we == exp_we, "R3/R5 slot_we", int'(slot_we), int'(exp_we));
                check(slot_start == exp_start, "R4/R5 slot_start", int'(slot_start), int'(exp_start));
                if (exp_we != '0)
                    check(int'(slot_waddr) == exp_addr, "R3 slot_waddr", int'(slot_waddr), exp_addr);
            end
            if (out_valid) begin
                check((slot_done & b_grp) == b_grp, "R6 read before done", int'(slot_done), int'(b_grp));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected out_valid", int'(out_data), 0);
                end else begin
                    logic [7:0] ed;
                    logic       ee;
                    ed = exp_q.pop_front();
                    ee = err_q.pop_front();
                    check(out_data == ed, "R7/R8/R9 out_data", int'(out_data), int'(ed));
                    check(vote_err == ee, "R8/R9 vote_err", int'(vote_err), int'(ee));
                end
            end
            if (prev_busy && !busy)
                check(prev_ov, "R10 busy fell without last word", int'(prev_ov), 1);
            prev_busy = busy;
            prev_ov   = out_valid;
        end
    end

    task automatic set_cfg(input int m, input logic [NS-1:0] mk, input int ln);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_mode = 2'(m); cfg_mask = mk; cfg_len = LW'(ln);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        b_mode = m; b_mask = mk; b_len = ln;
    endtask

    function automatic logic [NS-1:0] target(input int n);
        int k;
        int seen;
        if (b_mode == 1 || b_mode == 2) return group_of(b_mode, b_mask);
        k = n / b_len;
        seen = 0;
        for (int i = 0; i < NS; i++) begin
            if (b_mask[i]) begin
                if (seen == k) return NS'(1) << i;
                seen++;
            end
        end
        return '0;
    endfunction

    // one round: drive the burst, build expectations, wait for read-back
    task automatic run_round(input int base, input bit gaps, input bit inject);
        int total;
        logic [7:0] w [64];
        logic [NS-1:0] pend;
        bit redun;
        redun = (b_mode == 1 || b_mode == 2);
        b_grp = group_of(b_mode, b_mask);
        total = redun ? b_len : b_len * $countones(b_mask);
        for (int n = 0; n < total; n++) w[n] = 8'(n * 37 + base);
        if (redun) begin
            for (int n = 0; n < total; n++) begin
                logic [7:0] a, b, c;
                a = fx(w[n]) ^ fault[0]; b = fx(w[n]) ^ fault[1]; c = fx(w[n]) ^ fault[2];
                if (b_mode == 2) begin
                    exp_q.push_back((a & b) | (a & c) | (b & c));
                    err_q.push_back((a != b) || (a != c));
                end else begin
                    exp_q.push_back(a);
                    err_q.push_back(a != b);
                end
            end
        end else begin
            for (int n = 0; n < total; n++) begin
                exp_q.push_back(fx(w[n]));
                err_q.push_back(1'b0);
            end
        end
        @(posedge clk); #1; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        pend = '0;
        chk_en = 1'b1;
        for (int n = 0; n < total; n++) begin
            if (gaps && (n % 2 == 1)) begin
                in_valid = 1'b0; exp_we = '0; exp_start = pend; pend = '0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1; in_data = w[n];
            exp_we = target(n); exp_addr = n % b_len; exp_start = pend;
            pend = ((n % b_len) == b_len - 1) ? target(n) : '0;
            @(posedge clk); #1;
        end
        in_valid = 1'b0; exp_we = '0; exp_start = pend;
        @(posedge clk); #1;
        exp_start = '0;
        if (inject) begin
            cfg_we = 1'b1; cfg_mode = 2'd0; cfg_mask = 4'b0001; cfg_len = 8'd1; start = 1'b1;
            @(posedge clk); #1;
            cfg_we = 1'b0; start = 1'b0;
        end
        while (busy) @(posedge clk);
        #1;
        chk_en = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R7 missing results", exp_q.size(), 0);
        check(!busy, "R10 idle after round", int'(busy), 0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            fault[i] = '0;
            dly[i] = 2 + 3 * i;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !out_valid && !vote_err, "R1 reset outputs", int'({busy, out_valid, vote_err}), 0);
        check(slot_we == '0 && slot_re == '0 && slot_start == '0, "R1 reset slot ports",
              int'({slot_we, slot_re, slot_start}), 0);

        // R3 R4 R6 R7: split across all four slots, uneven finish times
        dly[0] = 9; dly[1] = 2; dly[2] = 6; dly[3] = 3;
        set_cfg(0, 4'b1111, 3);
        run_round(8'h10, 1'b0, 1'b0);

        // R3: sparse mask with idle bus cycles between words
        set_cfg(0, 4'b1010, 2);
        run_round(8'h40, 1'b1, 1'b0);

        // R5 R8: triple redundancy with one faulty slot
        fault[1] = 8'h24;
        set_cfg(2, 4'b0000, 4);
        run_round(8'h70, 1'b0, 1'b0);

        // R8: triple redundancy, all slots agree
        fault[1] = 8'h00;
        run_round(8'h90, 1'b0, 1'b0);

        // R9: double redundancy, slot 1 differs, then slot 0 differs
        fault[1] = 8'h81;
        set_cfg(1, 4'b0000, 3);
        run_round(8'hA0, 1'b0, 1'b0);
        fault[1] = 8'h00; fault[0] = 8'h03;
        run_round(8'hB0, 1'b0, 1'b0);
        fault[0] = 8'h00;

        // R2 R10: config write and start pulse during a round are ignored
        set_cfg(1, 4'b0000, 2);
        run_round(8'hC0, 1'b0, 1'b1);
        run_round(8'hD0, 1'b0, 1'b0);

        // R10: start ignored with zero length and with an empty split mask
        set_cfg(0, 4'b1111, 0);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(!busy, "R10 zero length start", int'(busy), 0);
        set_cfg(0, 4'b0000, 2);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(!busy, "R10 empty mask start", int'(busy), 0);

        // R11: four work-groups on two slots run as two rounds, then a mode change
        set_cfg(0, 4'b0011, 2);
        run_round(8'h05, 1'b0, 1'b0);
        run_round(8'h55, 1'b0, 1'b0);
        set_cfg(2, 4'b0000, 1);
        run_round(8'hE5, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule